// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block performs the single-cycle state update a small 32-bit soft processor core needs when it enters a handler for a hardware exception, a memory-management fault, an external interrupt, a hardware break or a software break. The core presents its current program counter, the pending branch target, the delay-slot and immediate-prefix flags, its machine status register (MSR), the fault details and a request mask. It also raises a one-cycle event strobe. On the next clock edge the block commits everything that entry requires: a PC redirect to the handler, a rewritten MSR, the return address written into a general register, and the exception status (ESR), branch-target (BTR) and fault-address (EAR) registers that it holds.

Each event class has its own handler vector and its own return register. On every entry the translation-enable and user-mode bits are saved into shadow bits and then cleared, so every handler starts untranslated and privileged. A fault taken inside a branch delay slot is marked in the ESR, and the branch target is kept so the handler can resume the branch. A second memory fault raised while a memory fault is still being serviced cannot be recovered. It is reported on a sticky error output and no further entries are committed.

Top module: `exc_entry_ctrl`

## Requirements
- R1: One cycle after a strobe edge with a taken event, `pc_load` pulses for one cycle with `pc_next` = 0x20 for a hardware exception or memory fault, 0x10 for an interrupt, 0x18 for a hardware break, and `br_target` (sampled at the strobe) for a software break.
- R2: In the same cycle `rf_we` pulses with `rf_wdata` = the sampled PC and `rf_waddr` = 17 for exceptions and memory faults, 14 for interrupts and 16 for hardware breaks. A software break writes no register.
- R3: On every entry `msr_load` pulses and `msr_next` equals `msr_in` with bit 14 taking bit 13 (translation), bit 12 taking bit 11 (user mode), and bits 13 and 11 cleared. All other bits are unchanged apart from R4.
- R4: Exception and memory-fault entry also sets MSR bit 9 (exception in progress). Both break kinds set MSR bit 3 (break in progress). Interrupt entry sets neither bit.
- R5: An exception or memory fault taken while `dslot` is 1 sets ESR bit 12 and loads BTR with `br_target`. Taken with `dslot` 0, ESR bit 12 is 0 and BTR keeps its value.
- R6: `flags_clr` pulses together with `pc_load` on exception and memory-fault entry only, to clear the delay-slot and immediate-prefix flags.
- R7: On a memory fault the ESR low code is 18 for a translation miss on data, 19 for a miss on an instruction fetch, 16 for a protection fault on data and 17 for one on a fetch, with ESR bit 10 set when `mf_store` is 1. A hardware exception loads the ESR with `hw_code` zero-extended.
- R8: A memory fault loads EAR with `fault_addr`. No other event changes EAR.
- R9: An interrupt is taken only when MSR bit 1 is 1, MSR bits 9 and 3 are 0 and `dslot` is 0. Otherwise it causes no output activity.
- R10: Request mask bits are [0] hardware exception, [1] memory fault, [2] interrupt, [3] hardware break, [4] software break. When several are set, the taken event follows the order memory fault, hardware exception, hardware break, software break, interrupt.
- R11: A memory fault whose strobe arrives while MSR bit 9 is 1 and the last committed exception was a memory fault, with bit 9 held high since then, sets `fatal_err` one cycle later. The flag stays set until reset and the fault commits nothing.
- R12: After reset all pulses are 0, ESR, BTR and EAR are 0 and `fatal_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | One-cycle event strobe |
| ev_req | input | 5 | Event request mask (R10 order) |
| pc_in | input | 32 | PC of the interrupted instruction |
| br_target | input | 32 | Pending branch target |
| dslot | input | 1 | Core is in a branch delay slot |
| imm_pfx | input | 1 | Immediate prefix pending |
| msr_in | input | 32 | Current machine status register |
| hw_code | input | 5 | Hardware exception cause code |
| mf_miss | input | 1 | Memory fault is a translation miss (else protection) |
| mf_ifetch | input | 1 | Memory fault on an instruction fetch |
| mf_store | input | 1 | Memory fault on a store |
| fault_addr | input | 32 | Faulting address |
| pc_load | output | 1 | PC redirect strobe |
| pc_next | output | 32 | Handler address |
| msr_load | output | 1 | MSR write strobe |
| msr_next | output | 32 | New MSR value |
| flags_clr | output | 1 | Clear delay-slot and prefix flags |
| rf_we | output | 1 | Return-address register write enable |
| rf_waddr | output | 5 | Return-address register index |
| rf_wdata | output | 32 | Return address |
| esr_o | output | 32 | Exception status register |
| btr_o | output | 32 | Branch-target register |
| ear_o | output | 32 | Fault-address register |
| fatal_err | output | 1 | Sticky unrecoverable nested-fault flag |

## Verification
The hardest case to reach is the unrecoverable nested memory fault. It needs one memory fault committed first, then MSR bit 9 held high without a gap, and only then a second memory fault. The bench gets there by raising bit 9 in the strobe cycle that directly follows the first fault's commit, so no clock edge sees it low. It also runs the near miss, a hardware exception followed by a memory fault under the same MSR, which must be taken normally. The delay-slot path is driven twice with different branch targets, to show that BTR follows only the fault taken in the slot.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  typedef enum logic [2:0] {
    CL_NONE, CL_MMU, CL_HWEXC, CL_HWBRK, CL_SWBRK, CL_IRQ
  } ev_class_e;

  localparam int REQ_W     = 5;
  localparam int REQ_HWEXC = 0;
  localparam int REQ_MMU   = 1;
  localparam int REQ_IRQ   = 2;
  localparam int REQ_HWBRK = 3;
  localparam int REQ_SWBRK = 4;

  localparam int MSR_IE  = 1;
  localparam int MSR_BIP = 3;
  localparam int MSR_EIP = 9;
  localparam int MSR_UM  = 11;
  localparam int MSR_UMS = 12;
  localparam int MSR_VM  = 13;
  localparam int MSR_VMS = 14;

  localparam int ESR_STORE = 10;
  localparam int ESR_DS    = 12;
endpackage

// File: rtl/exc_prio_sel.sv
module exc_prio_sel
  import exc_entry_pkg::*;
(
  input  logic             valid,
  input  logic [REQ_W-1:0] req,
  input  logic             irq_ok,
  output ev_class_e        cls
);
  always_comb begin
    cls = CL_NONE;
    if (valid) begin
      if (req[REQ_MMU])                 cls = CL_MMU;
      else if (req[REQ_HWEXC])          cls = CL_HWEXC;
      else if (req[REQ_HWBRK])          cls = CL_HWBRK;
      else if (req[REQ_SWBRK])          cls = CL_SWBRK;
      else if (req[REQ_IRQ] && irq_ok)  cls = CL_IRQ;
    end
  end
endmodule

// File: rtl/exc_esr_gen.sv
module exc_esr_gen
  import exc_entry_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int CODE_W = 5
) (
  input  ev_class_e         cls,
  input  logic [CODE_W-1:0] hw_code,
  input  logic              miss,
  input  logic              ifetch,
  input  logic              store,
  input  logic              dslot,
  output logic [XLEN-1:0]   esr_val
);
  localparam logic [XLEN-1:0] C_PROT_D = XLEN'(16);
  localparam logic [XLEN-1:0] C_PROT_I = XLEN'(17);
  localparam logic [XLEN-1:0] C_MISS_D = XLEN'(18);
  localparam logic [XLEN-1:0] C_MISS_I = XLEN'(19);

  always_comb begin
    esr_val = '0;
    if (cls == CL_MMU) begin
      if (miss) esr_val = ifetch ? C_MISS_I : C_MISS_D;
      else      esr_val = ifetch ? C_PROT_I : C_PROT_D;
      esr_val[ESR_STORE] = store;
    end else begin
      esr_val = XLEN'(hw_code);
    end
    if (dslot) esr_val[ESR_DS] = 1'b1;
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int RFAW    = 5,
  parameter int CODE_W  = 5,
  parameter logic [31:0] VEC_EXC = 32'h20,
  parameter logic [31:0] VEC_IRQ = 32'h10,
  parameter logic [31:0] VEC_BRK = 32'h18,
  parameter int RA_EXC  = 17,
  parameter int RA_IRQ  = 14,
  parameter int RA_BRK  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic [REQ_W-1:0]  ev_req,
  input  logic [XLEN-1:0]   pc_in,
  input  logic [XLEN-1:0]   br_target,
  input  logic              dslot,
  input  logic              imm_pfx,
  input  logic [XLEN-1:0]   msr_in,
  input  logic [CODE_W-1:0] hw_code,
  input  logic              mf_miss,
  input  logic              mf_ifetch,
  input  logic              mf_store,
  input  logic [XLEN-1:0]   fault_addr,
  output logic              pc_load,
  output logic [XLEN-1:0]   pc_next,
  output logic              msr_load,
  output logic [XLEN-1:0]   msr_next,
  output logic              flags_clr,
  output logic              rf_we,
  output logic [RFAW-1:0]   rf_waddr,
  output logic [XLEN-1:0]   rf_wdata,
  output logic [XLEN-1:0]   esr_o,
  output logic [XLEN-1:0]   btr_o,
  output logic [XLEN-1:0]   ear_o,
  output logic              fatal_err
);
  localparam logic [RFAW-1:0] RA_EXC_W = RFAW'(RA_EXC);
  localparam logic [RFAW-1:0] RA_IRQ_W = RFAW'(RA_IRQ);
  localparam logic [RFAW-1:0] RA_BRK_W = RFAW'(RA_BRK);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ok = rst_sync[1];

  ev_class_e       cls;
  logic            irq_ok;
  logic [XLEN-1:0] esr_val;
  logic            mmu_busy_q, mmu_busy_d;
  logic            fatal_hit;
  logic            commit;
  logic [XLEN-1:0] msr_saved;

  // the prefix flag never changes what entry does; it is only cleared
  logic            unused_imm;
  assign unused_imm = imm_pfx;

  assign irq_ok = msr_in[MSR_IE] && !msr_in[MSR_EIP] && !msr_in[MSR_BIP] && !dslot;

  exc_prio_sel u_sel (
    .valid (ev_valid && !fatal_err),
    .req   (ev_req),
    .irq_ok(irq_ok),
    .cls   (cls)
  );

  exc_esr_gen #(.XLEN(XLEN), .CODE_W(CODE_W)) u_esr (
    .cls    (cls),
    .hw_code(hw_code),
    .miss   (mf_miss),
    .ifetch (mf_ifetch),
    .store  (mf_store),
    .dslot  (dslot),
    .esr_val(esr_val)
  );

  assign fatal_hit = (cls == CL_MMU) && msr_in[MSR_EIP] && mmu_busy_q;
  assign commit    = (cls != CL_NONE) && !fatal_hit;

  always_comb begin
    msr_saved          = msr_in;
    msr_saved[MSR_VMS] = msr_in[MSR_VM];
    msr_saved[MSR_UMS] = msr_in[MSR_UM];
    msr_saved[MSR_VM]  = 1'b0;
    msr_saved[MSR_UM]  = 1'b0;
  end

  logic            pc_load_d, rf_we_d, flags_clr_d;
  logic [XLEN-1:0] pc_next_d, msr_next_d, esr_d, btr_d, ear_d;
  logic [RFAW-1:0] rf_waddr_d;

  always_comb begin
    pc_load_d   = commit;
    rf_we_d     = 1'b0;
    flags_clr_d = 1'b0;
    pc_next_d   = '0;
    msr_next_d  = msr_saved;
    rf_waddr_d  = '0;
    esr_d       = esr_o;
    btr_d       = btr_o;
    ear_d       = ear_o;
    mmu_busy_d  = msr_in[MSR_EIP] ? mmu_busy_q : 1'b0;
    if (commit) begin
      unique case (cls)
        CL_MMU, CL_HWEXC: begin
          pc_next_d           = VEC_EXC;
          rf_we_d             = 1'b1;
          rf_waddr_d          = RA_EXC_W;
          flags_clr_d         = 1'b1;
          msr_next_d[MSR_EIP] = 1'b1;
          esr_d               = esr_val;
          if (dslot) btr_d = br_target;
          mmu_busy_d          = (cls == CL_MMU);
          if (cls == CL_MMU) ear_d = fault_addr;
        end
        CL_HWBRK: begin
          pc_next_d           = VEC_BRK;
          rf_we_d             = 1'b1;
          rf_waddr_d          = RA_BRK_W;
          msr_next_d[MSR_BIP] = 1'b1;
        end
        CL_SWBRK: begin
          pc_next_d           = br_target;
          msr_next_d[MSR_BIP] = 1'b1;
        end
        CL_IRQ: begin
          pc_next_d  = VEC_IRQ;
          rf_we_d    = 1'b1;
          rf_waddr_d = RA_IRQ_W;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      pc_load    <= 1'b0;
      pc_next    <= '0;
      msr_load   <= 1'b0;
      msr_next   <= '0;
      flags_clr  <= 1'b0;
      rf_we      <= 1'b0;
      rf_waddr   <= '0;
      rf_wdata   <= '0;
      esr_o      <= '0;
      btr_o      <= '0;
      ear_o      <= '0;
      mmu_busy_q <= 1'b0;
      fatal_err  <= 1'b0;
    end else begin
      pc_load    <= pc_load_d;
      msr_load   <= pc_load_d;
      flags_clr  <= flags_clr_d;
      rf_we      <= rf_we_d;
      mmu_busy_q <= mmu_busy_d;
      if (pc_load_d) begin
        pc_next  <= pc_next_d;
        msr_next <= msr_next_d;
        rf_waddr <= rf_waddr_d;
        rf_wdata <= pc_in;
        esr_o    <= esr_d;
        btr_o    <= btr_d;
        ear_o    <= ear_d;
      end
      if (fatal_hit) fatal_err <= 1'b1;
    end
  end

  // R3
  mode_clear_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    msr_load |-> (!msr_next[MSR_VM] && !msr_next[MSR_UM] &&
                  msr_next[MSR_VMS] == $past(msr_in[MSR_VM]) &&
                  msr_next[MSR_UMS] == $past(msr_in[MSR_UM])));
  // R2
  ret_write_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    rf_we |-> (pc_load && rf_wdata == $past(pc_in)));
  // R6
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    flags_clr |-> (pc_load && pc_next == VEC_EXC && msr_next[MSR_EIP]));
  // R11
  fatal_sticky_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    fatal_err |=> (fatal_err && !pc_load));
  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (pc_load && rf_we && rf_waddr == RA_IRQ_W) |->
      ($past(msr_in[MSR_IE]) && !$past(msr_in[MSR_EIP]) && !$past(dslot)));
endmodule

// File: tb/exc_entry_ctrl_tb_top.sv
module exc_entry_ctrl_tb_top;
  localparam time TCLK = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ev_valid;
  logic [4:0]  ev_req;
  logic [31:0] pc_in, br_target, msr_in, fault_addr;
  logic        dslot, imm_pfx, mf_miss, mf_ifetch, mf_store;
  logic [4:0]  hw_code;
  logic        pc_load, msr_load, flags_clr, rf_we, fatal_err;
  logic [31:0] pc_next, msr_next, rf_wdata, esr_o, btr_o, ear_o;
  logic [4:0]  rf_waddr;

  int n_cmp = 0;
  int n_bad = 0;

  always #(TCLK/2) clk = ~clk;

  exc_entry_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_req(ev_req),
    .pc_in(pc_in), .br_target(br_target), .dslot(dslot), .imm_pfx(imm_pfx),
    .msr_in(msr_in), .hw_code(hw_code), .mf_miss(mf_miss),
    .mf_ifetch(mf_ifetch), .mf_store(mf_store), .fault_addr(fault_addr),
    .pc_load(pc_load), .pc_next(pc_next), .msr_load(msr_load),
    .msr_next(msr_next), .flags_clr(flags_clr), .rf_we(rf_we),
    .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .esr_o(esr_o),
    .btr_o(btr_o), .ear_o(ear_o), .fatal_err(fatal_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] msr_exp(input logic [31:0] m, input int setb);
    logic [31:0] r;
    r = m;
    r[14] = m[13];
    r[12] = m[11];
    r[13] = 1'b0;
    r[11] = 1'b0;
    if (setb >= 0) r[setb] = 1'b1;
    return r;
  endfunction

  // called at a negedge; returns at the negedge after the commit edge
  task automatic fire(input logic [4:0] req, input logic [31:0] msr, input logic ds);
    ev_req   = req;
    msr_in   = msr;
    dslot    = ds;
    ev_valid = 1'b1;
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R12 pc_load", {31'b0, pc_load}, 32'd0);
    chk("R12 rf_we", {31'b0, rf_we}, 32'd0);
    chk("R12 esr", esr_o, 32'd0);
    chk("R12 btr", btr_o, 32'd0);
    chk("R12 ear", ear_o, 32'd0);
    chk("R12 fatal", {31'b0, fatal_err}, 32'd0);
  endtask

  task automatic t_irq();
    logic [31:0] m;
    m = 32'h0000_2802;
    pc_in = 32'h0000_1234;
    fire(5'b00100, m, 1'b0);
    chk("R1 irq vector", pc_next, 32'h10);
    chk("R1 irq load", {31'b0, pc_load}, 32'd1);
    chk("R2 irq reg", {27'b0, rf_waddr}, 32'd14);
    chk("R2 irq data", rf_wdata, 32'h1234);
    chk("R3 R4 irq msr", msr_next, msr_exp(m, -1));
    chk("R6 irq no clr", {31'b0, flags_clr}, 32'd0);
    @(negedge clk);
    chk("R1 single pulse", {31'b0, pc_load}, 32'd0);
  endtask

  task automatic t_irq_masked();
    fire(5'b00100, 32'h0000_0000, 1'b0);
    chk("R9 ie clear", {30'b0, pc_load, rf_we}, 32'd0);
    fire(5'b00100, 32'h0000_0202, 1'b0);
    chk("R9 eip set", {30'b0, pc_load, rf_we}, 32'd0);
    fire(5'b00100, 32'h0000_000A, 1'b0);
    chk("R9 bip set", {30'b0, pc_load, rf_we}, 32'd0);
    fire(5'b00100, 32'h0000_0002, 1'b1);
    chk("R9 dslot", {30'b0, pc_load, rf_we}, 32'd0);
  endtask

  task automatic t_hwexc();
    logic [31:0] m;
    m = 32'h0000_0800;
    pc_in = 32'h0000_4000; br_target = 32'h0000_8888; hw_code = 5'd7;
    fire(5'b00001, m, 1'b1);
    chk("R1 exc vector", pc_next, 32'h20);
    chk("R2 exc reg", {27'b0, rf_waddr}, 32'd17);
    chk("R3 R4 exc msr", msr_next, msr_exp(m, 9));
    chk("R5 R7 esr ds", esr_o, 32'h0000_1007);
    chk("R5 btr", btr_o, 32'h8888);
    chk("R6 clr", {31'b0, flags_clr}, 32'd1);
    chk("R8 ear kept", ear_o, 32'd0);
    br_target = 32'h0000_9999; hw_code = 5'd3;
    fire(5'b00001, 32'h0, 1'b0);
    chk("R5 R7 esr no ds", esr_o, 32'h0000_0003);
    chk("R5 btr kept", btr_o, 32'h8888);
  endtask

  task automatic t_mmu();
    fault_addr = 32'hDEAD_0010;
    mf_miss = 1'b1; mf_ifetch = 1'b0; mf_store = 1'b1;
    fire(5'b00010, 32'h0000_2000, 1'b0);
    chk("R7 miss store", esr_o, 32'h0000_0412);
    chk("R8 ear", ear_o, 32'hDEAD_0010);
    chk("R1 mmu vector", pc_next, 32'h20);
    mf_ifetch = 1'b1; mf_store = 1'b0; fault_addr = 32'hBEEF_0000;
    fire(5'b00010, 32'h0, 1'b0);
    chk("R7 miss fetch", esr_o, 32'd19);
    mf_miss = 1'b0;
    fire(5'b00010, 32'h0, 1'b0);
    chk("R7 prot fetch", esr_o, 32'd17);
    mf_ifetch = 1'b0;
    fire(5'b00010, 32'h0, 1'b0);
    chk("R7 prot data", esr_o, 32'd16);
    fault_addr = 32'h1111_1111;
    fire(5'b01000, 32'h0, 1'b0);
    chk("R8 ear unchanged", ear_o, 32'hBEEF_0000);
  endtask

  task automatic t_break();
    logic [31:0] m;
    m = 32'h0000_2800;
    pc_in = 32'h0000_0500; br_target = 32'h0000_0700;
    fire(5'b01000, m, 1'b0);
    chk("R1 hw brk vector", pc_next, 32'h18);
    chk("R2 hw brk reg", {27'b0, rf_waddr}, 32'd16);
    chk("R4 hw brk msr", msr_next, msr_exp(m, 3));
    fire(5'b10000, m, 1'b0);
    chk("R1 sw brk target", pc_next, 32'h700);
    chk("R2 sw brk no write", {31'b0, rf_we}, 32'd0);
    chk("R4 sw brk msr", msr_next, msr_exp(m, 3));
  endtask

  task automatic t_prio();
    mf_miss = 1'b1; mf_ifetch = 1'b0; mf_store = 1'b0; hw_code = 5'd5;
    fire(5'b11111, 32'h2, 1'b0);
    chk("R10 mmu first", esr_o, 32'd18);
    fire(5'b11101, 32'h2, 1'b0);
    chk("R10 hwexc over brk", esr_o, 32'd5);
    fire(5'b11100, 32'h2, 1'b0);
    chk("R10 hwbrk", pc_next, 32'h18);
    br_target = 32'h0000_0ABC;
    fire(5'b10100, 32'h2, 1'b0);
    chk("R10 swbrk over irq", pc_next, 32'hABC);
  endtask

  task automatic t_fatal();
    hw_code = 5'd1;
    fire(5'b00001, 32'h0, 1'b0);
    fire(5'b00010, 32'h200, 1'b0);
    chk("R11 not after hwexc", {30'b0, fatal_err, pc_load}, 32'd1);
    fire(5'b00010, 32'h200, 1'b0);
    chk("R11 nested fatal", {30'b0, fatal_err, pc_load}, 32'd2);
    fire(5'b01000, 32'h200, 1'b0);
    chk("R11 sticky", {30'b0, fatal_err, pc_load}, 32'd2);
  endtask

  initial begin
    rst_n = 1'b0; ev_valid = 1'b0; ev_req = '0; pc_in = '0; br_target = '0;
    msr_in = '0; fault_addr = '0; dslot = 1'b0; imm_pfx = 1'b1;
    mf_miss = 1'b0; mf_ifetch = 1'b0; mf_store = 1'b0; hw_code = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_irq();
    t_irq_masked();
    t_hwexc();
    t_mmu();
    t_break();
    t_prio();
    t_fatal();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule